// File: doc/BRIEF.md
# Serial Flash Slave Byte Engine

This block stands in for a serial flash or non-volatile memory device on a byte-wide serial link. A byte-level front end delivers each received byte with a one-cycle strobe. One cycle later the engine returns the byte that the device would shift back for that slot. A chip-select release pulse ends the current command. The contents live in a register array whose size is set by a parameter.

The engine keeps a command across bytes. After a read or page-write opcode, it collects a three-byte address and then streams data at an address that counts up. A status opcode makes the rest of the transaction return zero. A write-enable latch gates page writes, and the latch can only be set while the `writable` input is high. An address at or beyond the array size causes no access, and the received byte is echoed back.

Top module: `flash_spi_slave_emu`

## Requirements
- R1: Opcode 0x03 (read) and an accepted opcode 0x0A (page write) clear the address. The next three bytes then form a 24-bit address, most significant byte first, and each of these three bytes is echoed back.
- R2: In the read data phase, each byte slot returns the array byte at the current address, and the address then increases by one.
- R3: In the page-write data phase, each received byte is stored at the current address, echoed back, and the address then increases by one.
- R4: When the current address is not below the array size, the data phase makes no access, the address does not change, and the received byte is echoed back.
- R5: Opcode 0x06 sets the write-enable latch only while `writable` is 1. Opcode 0x04 always clears the latch. Both opcodes are echoed back.
- R6: When the latch is clear, opcode 0x0A is refused. The response is 0x00, and the engine stays idle, so the next byte is decoded as an opcode.
- R7: Opcode 0x05 is echoed back, and every later byte of that command returns 0x00.
- R8: Opcode 0x00 and any unlisted opcode have no effect. They are echoed back, and the engine stays idle.
- R9: A `cs_release` pulse returns the engine to idle and keeps the write-enable latch. A byte strobed in the same cycle as the release is dropped and gets no response.
- R10: Each accepted byte produces exactly one `tx_valid` pulse in the following cycle. A synchronous low `rst_n` clears the command, the address, the latch and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Byte received from the host |
| cs_release | input | 1 | Pulse: chip select released, end command |
| writable | input | 1 | Configuration: array may be written |
| tx_valid | output | 1 | Pulse: `tx_byte` holds the response |
| tx_byte | output | 8 | Response byte for the previous slot |

## Verification
Data is written to and read from two addresses whose address bytes are each other's mirror image, so a reversed byte order would land out of range and show up as an echo. A page write that crosses the last array location shows where the boundary lies, since the first byte is stored and the second is echoed. Page-write opcodes are sent after write enable with `writable` low, after write disable, after a chip-select release, and after a reset, so each way the latch can be set, cleared or kept is separated from the others. Status, no-op and unknown opcodes are each followed by a read opcode, which shows whether the engine stayed idle.

// File: rtl/flash_emu_pkg.sv
// Package: opcode values, engine states and response selectors shared by
// the serial flash byte engine. Assumes 8-bit bytes on the link.
package flash_emu_pkg;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_WDIS = 8'h04;
    localparam logic [7:0] OPC_STAT = 8'h05;
    localparam logic [7:0] OPC_WEN  = 8'h06;
    localparam logic [7:0] OPC_PROG = 8'h0A;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_PROG = 2'd2,
        ST_STAT = 2'd3
    } eng_state_e;

    typedef enum logic [1:0] {
        RSP_ECHO = 2'd0,
        RSP_MEM  = 2'd1,
        RSP_ZERO = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/flash_cmd_ctrl.sv
// Command controller: decodes opcodes, collects the address bytes, keeps the
// write-enable latch and drives the array write port and response selector.
// Assumes at most one byte per cycle; a release in the same cycle drops it.
module flash_cmd_ctrl
    import flash_emu_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int ADDR_BYTES = 3,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int IDX_W     = $clog2(MEM_BYTES),
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       rx_byte,
    input  logic             cs_release,
    input  logic             writable,
    output logic             accept,
    output rsp_kind_e        rsp_kind,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output logic [7:0]       mem_wdata
);

    localparam logic [ADDR_W-1:0] SIZE_A = ADDR_W'(MEM_BYTES);
    localparam logic [CNT_W-1:0]  CNT_LD = CNT_W'(ADDR_BYTES);

    eng_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              wel_q, wel_d;
    logic              in_range;

    assign accept    = byte_valid && !cs_release;
    assign in_range  = addr_q < SIZE_A;
    assign mem_idx   = addr_q[IDX_W-1:0];
    assign mem_wdata = rx_byte;

    // Next-state decode for one received byte or a release.
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        cnt_d    = cnt_q;
        wel_d    = wel_q;
        mem_we   = 1'b0;
        rsp_kind = RSP_ECHO;
        if (accept) begin
            unique case (state_q)
                ST_IDLE: begin
                    unique case (rx_byte)
                        OPC_READ: begin
                            state_d = ST_READ;
                            addr_d  = '0;
                            cnt_d   = CNT_LD;
                        end
                        OPC_WEN:  if (writable) wel_d = 1'b1;
                        OPC_WDIS: wel_d = 1'b0;
                        OPC_PROG: begin
                            if (wel_q) begin
                                state_d = ST_PROG;
                                addr_d  = '0;
                                cnt_d   = CNT_LD;
                            end else begin
                                rsp_kind = RSP_ZERO;
                            end
                        end
                        OPC_STAT: state_d = ST_STAT;
                        default:  ;
                    endcase
                end
                ST_READ, ST_PROG: begin
                    if (cnt_q != '0) begin
                        addr_d = {addr_q[ADDR_W-9:0], rx_byte};
                        cnt_d  = cnt_q - 1'b1;
                    end else if (in_range) begin
                        addr_d = addr_q + 1'b1;
                        if (state_q == ST_READ) rsp_kind = RSP_MEM;
                        else                    mem_we   = 1'b1;
                    end
                end
                ST_STAT: rsp_kind = RSP_ZERO;
                default: ;
            endcase
        end
        if (cs_release) state_d = ST_IDLE;
    end

    // State, address, counter and latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            wel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
            wel_q   <= wel_d;
        end
    end

    AST_WEN_NEEDS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == ST_IDLE && rx_byte == OPC_WEN && !writable) |=> (wel_q == $past(wel_q))); // R5
    AST_WDIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == ST_IDLE && rx_byte == OPC_WDIS) |=> !wel_q); // R5
    AST_PROG_ENTRY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> $past(wel_q)); // R6
    AST_RELEASE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_release |=> (state_q == ST_IDLE)); // R9
    AST_RELEASE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_release |=> $stable(wel_q)); // R9
    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == ST_READ && cnt_q == '0 && in_range) |=> (addr_q == $past(addr_q) + 1'b1)); // R2
    AST_OOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q != ST_IDLE && state_q != ST_STAT && cnt_q == '0 && !in_range) |=> $stable(addr_q)); // R4

endmodule

// File: rtl/flash_mem_array.sv
// Storage array: one synchronous write port and one combinational read port.
// Assumes the caller only presents in-range indices; contents are not reset.
module flash_mem_array #(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] cells [MEM_BYTES];

    // Store a byte when the controller requests it.
    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    // Read the byte at the current index.
    assign rdata = cells[idx];

endmodule

// File: rtl/flash_rsp_reg.sv
// Response register: picks echo, array data or zero and registers it with a
// one-cycle valid pulse. Assumes one accepted byte per cycle at most.
module flash_rsp_reg
    import flash_emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  rsp_kind_e  rsp_kind,
    input  logic [7:0] rx_byte,
    input  logic [7:0] mem_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);

    logic [7:0] rsp_d;

    // Select the response for the current slot.
    always_comb begin
        unique case (rsp_kind)
            RSP_MEM:  rsp_d = mem_rdata;
            RSP_ZERO: rsp_d = 8'h00;
            default:  rsp_d = rx_byte;
        endcase
    end

    // Register the response and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= 8'h00;
        end else begin
            tx_valid <= accept;
            if (accept) tx_byte <= rsp_d;
        end
    end

endmodule

// File: rtl/flash_spi_slave_emu.sv
// Top: serial flash byte engine. Joins the command controller, the storage
// array and the response register. Assumes a byte front end that strobes
// one received byte per cycle at most and pulses cs_release on deselect.
module flash_spi_slave_emu
    import flash_emu_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int ADDR_BYTES = 3,
    localparam int IDX_W     = $clog2(MEM_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] rx_byte,
    input  logic       cs_release,
    input  logic       writable,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);

    logic             accept;
    rsp_kind_e        rsp_kind;
    logic             mem_we;
    logic [IDX_W-1:0] mem_idx;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata;

    flash_cmd_ctrl #(
        .MEM_BYTES (MEM_BYTES),
        .ADDR_BYTES(ADDR_BYTES)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .rx_byte   (rx_byte),
        .cs_release(cs_release),
        .writable  (writable),
        .accept    (accept),
        .rsp_kind  (rsp_kind),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata)
    );

    flash_mem_array #(
        .MEM_BYTES(MEM_BYTES)
    ) i_mem (
        .clk  (clk),
        .we   (mem_we),
        .idx  (mem_idx),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    flash_rsp_reg i_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .rsp_kind (rsp_kind),
        .rx_byte  (rx_byte),
        .mem_rdata(mem_rdata),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !cs_release) |=> tx_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && !cs_release) |=> !tx_valid); // R10

endmodule

// File: tb/test_flash_spi_slave_emu.sv
`timescale 1ns/100ps
module test_flash_spi_slave_emu;

    localparam int MEM_BYTES = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       cs_release = 1'b0;
    logic       writable = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    flash_spi_slave_emu #(.MEM_BYTES(MEM_BYTES)) i_flash_spi_slave_emu (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .rx_byte   (rx_byte),
        .cs_release(cs_release),
        .writable  (writable),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

    // Monitor: pops one expected item per response pulse and compares.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected response actual=%02h expected=none", tx_byte);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                if (tx_byte !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, tx_byte, it.exp);
                end
            end
        end
    end

    // Driver: one byte slot, called at a falling edge.
    task automatic send(input logic [7:0] b, input logic [7:0] exp, input string tag);
        byte_valid = 1'b1;
        rx_byte    = b;
        exp_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic release_cs();
        cs_release = 1'b1;
        @(negedge clk);
        cs_release = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send_addr(input logic [23:0] a, input string tag);
        send(a[23:16], a[23:16], tag);
        send(a[15:8],  a[15:8],  tag);
        send(a[7:0],   a[7:0],   tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(tx_valid === 1'b0, "R10 reset valid", {7'd0, tx_valid}, 8'h00);
        check(tx_byte === 8'h00, "R10 reset byte", tx_byte, 8'h00);
        rst_n = 1'b1;
        idle(1);

        // R6: page write refused when the latch is clear; next byte is an opcode
        send(8'h0A, 8'h00, "R6 refused");
        send(8'h12, 8'h12, "R8 unknown after refuse");
        release_cs();

        // R5: enable ignored while not writable
        writable = 1'b0;
        send(8'h06, 8'h06, "R5 wen echo");
        send(8'h0A, 8'h00, "R5 wen blocked");
        release_cs();

        // R5/R9: enable while writable, latch survives a release
        writable = 1'b1;
        send(8'h06, 8'h06, "R5 wen echo");
        release_cs();
        send(8'h0A, 8'h0A, "R9 latch kept");
        send_addr(24'h000010, "R1 addr echo");
        send(8'hA1, 8'hA1, "R3 write echo");
        send(8'hB2, 8'hB2, "R3 write echo");
        send(8'hC3, 8'hC3, "R3 write echo");
        release_cs();

        // R2: read back the three bytes
        send(8'h03, 8'h03, "R1 read opcode");
        send_addr(24'h000010, "R1 addr echo");
        send(8'h00, 8'hA1, "R2 read");
        send(8'h00, 8'hB2, "R2 read");
        send(8'h00, 8'hC3, "R2 read");
        release_cs();

        // R1: byte order; the mirrored address is out of range
        send(8'h0A, 8'h0A, "R1 prog");
        send_addr(24'h000301, "R1 addr echo");
        send(8'h5A, 8'h5A, "R3 write echo");
        release_cs();
        send(8'h03, 8'h03, "R1 read opcode");
        send_addr(24'h000301, "R1 addr echo");
        send(8'h00, 8'h5A, "R1 msb first");
        release_cs();
        send(8'h03, 8'h03, "R1 read opcode");
        send_addr(24'h010300, "R1 addr echo");
        send(8'h3C, 8'h3C, "R4 mirrored out of range");
        release_cs();

        // R4: write across the last location
        send(8'h0A, 8'h0A, "R4 prog");
        send_addr(24'h0003FF, "R4 addr echo");
        send(8'h77, 8'h77, "R4 last write");
        send(8'h88, 8'h88, "R4 beyond echo");
        release_cs();
        send(8'h03, 8'h03, "R4 read opcode");
        send_addr(24'h0003FF, "R4 addr echo");
        send(8'h00, 8'h77, "R4 last read");
        send(8'hEE, 8'hEE, "R4 beyond read echo");
        release_cs();

        // R5: disable clears the latch
        send(8'h04, 8'h04, "R5 wdis echo");
        send(8'h0A, 8'h00, "R5 wdis blocks");
        release_cs();

        // R7: status returns zero for the rest of the command
        send(8'h05, 8'h05, "R7 stat echo");
        send(8'hFF, 8'h00, "R7 stat zero");
        send(8'h03, 8'h00, "R7 stat zero");
        send(8'h5A, 8'h00, "R7 stat zero");
        release_cs();

        // R8: no-op and unknown opcodes keep the engine idle
        send(8'h00, 8'h00, "R8 noop");
        send(8'h5C, 8'h5C, "R8 unknown");
        send(8'h03, 8'h03, "R8 still idle");
        send_addr(24'h000011, "R1 addr echo");
        send(8'h00, 8'hB2, "R8 read after noop");
        // R9: release mid read returns to idle
        release_cs();
        send(8'h10, 8'h10, "R9 idle after release");

        // R9: byte with release in the same cycle is dropped
        byte_valid = 1'b1;
        rx_byte    = 8'h03;
        cs_release = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        cs_release = 1'b0;
        check(tx_valid === 1'b0, "R9 dropped byte", {7'd0, tx_valid}, 8'h00);
        send(8'h05, 8'h05, "R9 dropped byte not opcode");
        send(8'h44, 8'h00, "R7 stat zero");
        release_cs();

        // R10: reset clears the latch
        send(8'h06, 8'h06, "R10 wen echo");
        idle(2);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        send(8'h0A, 8'h00, "R10 latch cleared by reset");

        idle(4);
        check(exp_q.size() == 0, "R10 missing responses", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule